// File: doc/BRIEF.md
# Configurable Serial Bit-Rate Tick Generator

This block divides the system clock down to the bit rate of a serial port. A free-running divisor counter runs from zero to a programmed value `n`. A second prescale counter divides the divisor counter's terminal counts by 64, 16 or 4. One bit-period tick is therefore emitted every `P × (n + 1)` clock cycles. The prescale ratio `P` and the counter width (8 or 16 bits) come from three mode inputs: synchronous select, wide-counter enable and high-speed select.

Writing a new divisor clears both counters in the same edge. The new rate starts at once and does not wait for the old period to run out. In asynchronous mode the block also pulses a sample strobe three times near the middle of each bit period. A small majority-vote stage uses those strobes to sample the receive line and resolve the bit level.

A typical use: a 16 MHz clock with 8-bit asynchronous mode, high-speed off and a divisor of 25 gives a 1664-cycle bit period, which is 9615 baud.

Top module: `baud_rate_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `bit_tick` and `sample_tick` are 0 and `rx_bit` is 1. Reset also clears the stored divisor to 0.
- R2: Asynchronous mode (`sync_mode`=0) with `wide_mode`=0 and `fast_mode`=0 emits one `bit_tick` every 64×(n+1) cycles.
- R3: Asynchronous mode with `wide_mode`=0 and `fast_mode`=1 emits one `bit_tick` every 16×(n+1) cycles.
- R4: Asynchronous mode with `wide_mode`=1 emits one `bit_tick` every 4×(n+1) cycles when `fast_mode`=1, and every 16×(n+1) cycles when `fast_mode`=0.
- R5: Synchronous mode (`sync_mode`=1) emits one `bit_tick` every 4×(n+1) cycles with either counter width. `fast_mode` has no effect in this mode.
- R6: With `wide_mode`=0, only `div_in[7:0]` sets `n`, and the upper byte of the stored divisor has no effect on the period.
- R7: A cycle with `div_wr`=1 stores `div_in` and clears both counters at that clock edge. The first `bit_tick` then falls exactly P×(n+1) cycles after the write cycle, counting the first cycle after the write as cycle 1, and never in the cycle right after the write.
- R8: `bit_tick` is high for exactly one cycle per bit period.
- R9: In asynchronous mode `sample_tick` pulses exactly three times per bit period. The pulses come at the divisor-counter terminal counts where the prescale count equals P/2−1, P/2 and P/2+1. In synchronous mode `sample_tick` stays 0.
- R10: `rx_bit` takes the majority of the three `rx_line` values sampled at one bit's `sample_tick` pulses. It updates on the edge of the third sample and does not change at any other time.
- R11: A divisor of 0 gives the fastest period of the current mode: P cycles, that is 64, 16 or 4.
- R12: With divisor 25 in 8-bit asynchronous mode with high-speed off, the period is 1664 cycles. With a 16 MHz clock this is 16000000/1664 = 9615 baud.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_in | input | 16 | Divisor value n to store |
| div_wr | input | 1 | Divisor write strobe; also restarts the counters |
| sync_mode | input | 1 | 1 = synchronous master mode, 0 = asynchronous |
| wide_mode | input | 1 | 1 = 16-bit divisor counter, 0 = 8-bit |
| fast_mode | input | 1 | High-speed select (asynchronous mode only) |
| rx_line | input | 1 | Receive data line to be voted |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| sample_tick | output | 1 | Sample-point strobe, three per bit (asynchronous) |
| rx_bit | output | 1 | Majority-voted receive bit |

## Verification
Properties check the timing rules on every cycle:
- `bit_tick` is never wider than one cycle.
- A divisor write is never followed by a tick or a sample strobe in the next cycle.
- Synchronous mode never produces a sample strobe.
- The voted bit changes only right after a sample strobe.
- The reset values are correct.

The division ratios for each mode code, the ignored upper byte in 8-bit mode, the exact latency after a mid-period rewrite, the three-strobe count per bit and the majority outcomes for mixed samples all depend on long cycle counts. Only the bench's directed scenarios can show them.

// File: rtl/baud_rate_pkg.sv
// Package: shared types and helpers for the bit-rate tick generator.
// Assumes the mode inputs are static between divisor writes.
package baud_rate_pkg;

    typedef enum logic [1:0] {
        PS_SLOW = 2'd0,
        PS_MID  = 2'd1,
        PS_FAST = 2'd2
    } prescale_sel_e;

    // Maps the three mode inputs onto a prescale choice.
    function automatic prescale_sel_e pick_prescale(input logic sync_m,
                                                    input logic wide_m,
                                                    input logic fast_m);
        prescale_sel_e sel;
        if (sync_m)
            sel = PS_FAST;
        else if (wide_m && fast_m)
            sel = PS_FAST;
        else if (wide_m || fast_m)
            sel = PS_MID;
        else
            sel = PS_SLOW;
        return sel;
    endfunction

    // Three-input majority.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/baud_div_counter.sv
// Module: divisor register and free-running divisor counter.
// Produces base_tick once every (n+1) cycles, n being the stored divisor
// truncated to NARROW_W bits unless wide_m is set. A write clears the count.
// Assumes NARROW_W < DIV_W.
module baud_div_counter #(
    parameter int DIV_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_in,
    input  logic             div_wr,
    input  logic             wide_m,
    output logic             base_tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Select the effective terminal value for the active counter width.
    always_comb begin
        limit = div_q;
        if (!wide_m)
            limit[DIV_W-1:NARROW_W] = '0;
    end

    // Terminal count; >= keeps the counter safe after a width change.
    assign base_tick = (cnt_q >= limit);

    // Store the divisor and run the counter, restarting on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_wr) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (base_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/baud_prescaler.sv
// Module: prescale counter advancing on divisor terminal counts.
// Divides base ticks by SLOW_DIV, MID_DIV or FAST_DIV, flags the bit tick
// and, in asynchronous mode, three sample strobes around the mid point.
// Assumes every ratio is at least 4 and SLOW_DIV is the largest.
module baud_prescaler
    import baud_rate_pkg::*;
#(
    parameter int SLOW_DIV = 64,
    parameter int MID_DIV  = 16,
    parameter int FAST_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          base_tick,
    input  prescale_sel_e sel,
    input  logic          sync_m,
    output logic          bit_tick,
    output logic          sample_tick,
    output logic          sample_last
);
    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam int EXT_W = CNT_W + 1;
    localparam logic [EXT_W-1:0] SLOW_R = EXT_W'(SLOW_DIV);
    localparam logic [EXT_W-1:0] MID_R  = EXT_W'(MID_DIV);
    localparam logic [EXT_W-1:0] FAST_R = EXT_W'(FAST_DIV);

    logic [CNT_W-1:0] pre_q;
    logic [EXT_W-1:0] pre_ext;
    logic [EXT_W-1:0] ratio;
    logic [EXT_W-1:0] mid;
    logic             wrap;
    logic             in_window;

    // Pick the division ratio from the selected prescale.
    always_comb begin
        unique case (sel)
            PS_MID:  ratio = MID_R;
            PS_FAST: ratio = FAST_R;
            default: ratio = SLOW_R;
        endcase
    end

    // Derive wrap point and sample window from the ratio.
    always_comb begin
        pre_ext   = {1'b0, pre_q};
        mid       = ratio >> 1;
        wrap      = (pre_ext >= ratio - EXT_W'(1));
        in_window = (pre_ext == mid - EXT_W'(1)) || (pre_ext == mid) ||
                    (pre_ext == mid + EXT_W'(1));
    end

    assign bit_tick    = base_tick && wrap;
    assign sample_tick = base_tick && !sync_m && in_window;
    assign sample_last = sample_tick && (pre_ext == mid + EXT_W'(1));

    // Advance the prescale count on terminal counts; clear on divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clear)
            pre_q <= '0;
        else if (base_tick)
            pre_q <= wrap ? '0 : pre_q + CNT_W'(1);
    end
endmodule

// File: rtl/rx_majority.sv
// Module: three-sample majority vote of the receive line.
// Holds the first two samples of a bit and resolves the level on the third.
// Assumes sample strobes arrive in groups of three, the last flagged.
module rx_majority
    import baud_rate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic sample_tick,
    input  logic sample_last,
    output logic rx_bit
);
    logic [1:0] early_q;

    // Capture early samples and resolve the bit on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q <= 2'b11;
            rx_bit  <= 1'b1;
        end else if (sample_last) begin
            rx_bit  <= vote3(early_q[1], early_q[0], rx_line);
        end else if (sample_tick) begin
            early_q <= {early_q[0], rx_line};
        end
    end
endmodule

// File: rtl/baud_rate_gen.sv
// Module: top of the bit-rate tick generator.
// Wires the divisor counter, the prescaler and the receive vote together.
// Assumes mode inputs change only together with a divisor write.
module baud_rate_gen
    import baud_rate_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int NARROW_W = 8,
    parameter int SLOW_DIV = 64,
    parameter int MID_DIV  = 16,
    parameter int FAST_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_in,
    input  logic             div_wr,
    input  logic             sync_mode,
    input  logic             wide_mode,
    input  logic             fast_mode,
    input  logic             rx_line,
    output logic             bit_tick,
    output logic             sample_tick,
    output logic             rx_bit
);
    logic          base_tick;
    logic          sample_last;
    prescale_sel_e sel;

    // Decode the mode inputs into a prescale choice.
    always_comb sel = pick_prescale(sync_mode, wide_mode, fast_mode);

    baud_div_counter #(
        .DIV_W    (DIV_W),
        .NARROW_W (NARROW_W)
    ) div_cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_in    (div_in),
        .div_wr    (div_wr),
        .wide_m    (wide_mode),
        .base_tick (base_tick)
    );

    baud_prescaler #(
        .SLOW_DIV (SLOW_DIV),
        .MID_DIV  (MID_DIV),
        .FAST_DIV (FAST_DIV)
    ) prescale_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (div_wr),
        .base_tick   (base_tick),
        .sel         (sel),
        .sync_m      (sync_mode),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .sample_last (sample_last)
    );

    rx_majority vote_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .sample_tick (sample_tick),
        .sample_last (sample_last),
        .rx_bit      (rx_bit)
    );
endmodule

// File: rtl/baud_rate_gen_chk.sv
// Module: property checker for baud_rate_gen, attached by bind.
// Observes ports only.
module baud_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic div_wr,
    input logic sync_mode,
    input logic bit_tick,
    input logic sample_tick,
    input logic rx_bit
);
    // R1: reset leaves outputs idle in the following cycle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!bit_tick && !sample_tick && rx_bit));

    // R8: the bit tick never lasts two cycles.
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R7: a divisor write restarts the counters, so no pulse follows at once.
    assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (!bit_tick && !sample_tick));

    // R9: synchronous mode never strobes the sample point.
    assert_sync_no_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> !sample_tick);

    // R10: the voted bit moves only on the edge that takes a sample.
    assert_vote_on_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> $past(sample_tick));
endmodule

bind baud_rate_gen baud_rate_gen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_wr      (div_wr),
    .sync_mode   (sync_mode),
    .bit_tick    (bit_tick),
    .sample_tick (sample_tick),
    .rx_bit      (rx_bit)
);

// File: tb/baud_rate_gen_tb_top.sv
// Bench: directed scenarios for baud_rate_gen, one task per scenario.
module baud_rate_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_in = '0;
    logic        div_wr = 1'b0;
    logic        sync_mode = 1'b0;
    logic        wide_mode = 1'b0;
    logic        fast_mode = 1'b0;
    logic        rx_line = 1'b1;
    logic        bit_tick;
    logic        sample_tick;
    logic        rx_bit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    baud_rate_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_in      (div_in),
        .div_wr      (div_wr),
        .sync_mode   (sync_mode),
        .wide_mode   (wide_mode),
        .fast_mode   (fast_mode),
        .rx_line     (rx_line),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .rx_bit      (rx_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic s, input logic w, input logic f);
        @(negedge clk);
        sync_mode = s; wide_mode = w; fast_mode = f;
    endtask

    // Write n, then measure write-to-tick latency, samples seen, and next period.
    task automatic run_period(input logic [15:0] n, input int exp_p,
                              input int exp_samp, input string tag);
        int lat = 0;
        int per = 0;
        int samp = 0;
        @(negedge clk);
        div_in = n; div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        forever begin
            lat++;
            if (sample_tick) samp++;
            if (bit_tick || lat > 20000) break;
            @(negedge clk);
        end
        check(lat == exp_p, {tag, " latency"}, lat, exp_p);
        check(samp == exp_samp, {tag, " R9 samples"}, samp, exp_samp);
        @(negedge clk);
        forever begin
            per++;
            if (bit_tick || per > 20000) break;
            @(negedge clk);
        end
        check(per == exp_p, {tag, " period"}, per, exp_p);
    endtask

    task automatic t_reset;
        check(!bit_tick && !sample_tick, "R1 outputs idle", {bit_tick, sample_tick}, 0);
        check(rx_bit == 1'b1, "R1 rx_bit", rx_bit, 1);
    endtask

    task automatic t_async_narrow;
        set_mode(0, 0, 0);
        run_period(16'd3, 256, 3, "R2 x64 n=3");
        run_period(16'd0, 64, 3, "R11 x64 n=0");
        set_mode(0, 0, 1);
        run_period(16'd7, 128, 3, "R3 x16 n=7");
        run_period(16'd0, 16, 3, "R11 x16 n=0");
    endtask

    task automatic t_async_wide;
        set_mode(0, 1, 1);
        run_period(16'd300, 1204, 3, "R4 x4 wide n=300");
        run_period(16'd0, 4, 3, "R11 x4 n=0");
        set_mode(0, 1, 0);
        run_period(16'd300, 4816, 3, "R4 x16 wide n=300");
    endtask

    task automatic t_sync;
        set_mode(1, 0, 0);
        run_period(16'd9, 40, 0, "R5 sync fast=0");
        set_mode(1, 0, 1);
        run_period(16'd9, 40, 0, "R5 sync fast=1");
        set_mode(1, 1, 0);
        run_period(16'h0102, 1036, 0, "R5 sync wide");
    endtask

    task automatic t_narrow_ignores_high;
        set_mode(0, 0, 0);
        run_period(16'h0305, 384, 3, "R6 high byte ignored");
    endtask

    task automatic t_example_rate;
        int baud;
        set_mode(0, 0, 0);
        run_period(16'd25, 1664, 3, "R12 n=25");
        baud = 16000000 / 1664;
        check(baud == 9615, "R12 rate", baud, 9615);
    endtask

    task automatic t_restart;
        int lat = 0;
        set_mode(0, 1, 1);
        @(negedge clk);
        div_in = 16'd100; div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        repeat (150) @(negedge clk);
        div_in = 16'd10; div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        check(!bit_tick, "R7 no tick after write", bit_tick, 0);
        forever begin
            lat++;
            if (bit_tick || lat > 20000) break;
            @(negedge clk);
        end
        check(lat == 44, "R7 restart latency", lat, 44);
    endtask

    // Drive one value per sample strobe of a bit, then check the vote.
    task automatic vote_bit(input logic v0, input logic v1, input logic v2,
                            input logic exp, input string tag);
        logic vals [3];
        vals[0] = v0; vals[1] = v1; vals[2] = v2;
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            while (!sample_tick) @(negedge clk);
            rx_line = vals[i];
            @(negedge clk);
        end
        check(rx_bit == exp, tag, rx_bit, exp);
        rx_line = ~exp;
        @(negedge clk);
        check(rx_bit == exp, {tag, " held between samples"}, rx_bit, exp);
    endtask

    task automatic t_vote;
        set_mode(0, 1, 1);
        @(negedge clk);
        div_in = 16'd2; div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        vote_bit(0, 0, 0, 0, "R10 vote 000");
        vote_bit(1, 0, 1, 1, "R10 vote 101");
        vote_bit(0, 1, 0, 0, "R10 vote 010");
        vote_bit(1, 1, 0, 1, "R10 vote 110");
        vote_bit(0, 0, 1, 0, "R10 vote 001");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_async_narrow();
        t_async_wide();
        t_sync();
        t_narrow_ignores_high();
        t_example_rate();
        t_restart();
        t_vote();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule